// File: doc/BRIEF.md
# Decimal Matrix Decoder with Shared Check Generator

This block protects a 64-bit memory word against clustered multi-cell upsets. The word is split into 4-bit symbols and laid out as a logical grid of two rows by eight columns. Inside each row, symbol `p` is paired with symbol `p+4`, and the pair is summed as unsigned integers into a 5-bit horizontal check. Every data bit is XORed with the bit in the same position of the other row, which gives a vertical check. The stored 136-bit codeword is the 64 data bits, then the 40 horizontal bits, then the 32 vertical bits.

A single check generator serves both directions, selected by the mode input `en_read`, which the memory's read/write control drives:

- **Write (`en_read`=0):** the generator encodes `wr_data` into `cw_out`.
- **Read (`en_read`=1):** the generator recomputes the checks from the data field of `cw_in`. Horizontal syndromes are formed by integer subtraction of the stored sums from the recomputed sums, and vertical syndromes by XOR. Each symbol whose group syndrome and column syndrome are both nonzero is corrected by XORing it with its column's vertical syndrome.

Every result is registered, so it appears one clock after the inputs.

Top module: `dmc_decoder_ert`

## Requirements
- R1: While `rst_n` is low, `cw_out`, `rd_data`, `err_det` and `err_fix` are all zero.
- R2: One cycle after a write cycle, `cw_out` holds the encoded word:
  - bits [63:0] are the data;
  - bits [64+5g+4:64+5g] hold the sum of symbol (r, q) and symbol (r, q+4), where g = 4r+q, and symbol (r, p) is data[32r+4p+3 : 32r+4p];
  - bit 104+j is data[j] XOR data[j+32], for j in 0..31.
- R3: A write cycle leaves `rd_data`, `err_det` and `err_fix` unchanged.
- R4: A read cycle leaves `cw_out` unchanged.
- R5: A read of a valid codeword returns its data field one cycle later, with `err_det`=0 and `err_fix`=0.
- R6: A read in which any nonzero set of bits is flipped inside one data symbol returns the original data, with `err_det`=1 and `err_fix`=1.
- R7: A read with flips in two data symbols of the same row, whose column positions differ modulo 4, returns the original data, with both flags set.
- R8: A read in which only horizontal check bits (codeword bits 103:64) are corrupted returns the data field unchanged, with `err_det`=1 and `err_fix`=0.
- R9: A read in which only vertical check bits (codeword bits 135:104) are corrupted returns the data field unchanged, with `err_det`=1 and `err_fix`=0.
- R10: `err_fix` is never 1 while `err_det` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_read | input | 1 | 1 = decode `cw_in`, 0 = encode `wr_data` |
| wr_data | input | 64 | Data word to encode |
| cw_in | input | 136 | Codeword read back from memory |
| cw_out | output | 136 | Encoded codeword for the memory write |
| rd_data | output | 64 | Corrected read data |
| err_det | output | 1 | Some syndrome was nonzero on the last read |
| err_fix | output | 1 | At least one symbol was corrected on the last read |

## Verification
The pass-through assertion assumes that a read reporting no error carried a codeword consistent with its own checks. The decoder has no way to notice an upset whose recomputed sums and parities happen to match the stored ones. The stimulus therefore builds every read from a codeword encoded by a bench model. Errors are injected only in patterns the requirements promise to handle:

- one symbol;
- two symbols of one row at positions distinct modulo 4;
- the horizontal field alone;
- the vertical field alone.

Patterns that could alias to another symbol are never injected.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   typedef enum logic {
      MODE_WR = 1'b0,
      MODE_RD = 1'b1
   } dmc_mode_e;

   // Horizontal group that a symbol at (row, pos) belongs to.
   function automatic int grp_idx(input int row, input int pos, input int half);
      return row * half + (pos % half);
   endfunction

endpackage

// File: rtl/dmc_chkgen.sv
module dmc_chkgen #(
   parameter int SYM_W = 4,
   parameter int ROWS  = 2,
   parameter int COLS  = 8
) (
   input  logic [SYM_W*COLS*ROWS-1:0]           data_i,
   output logic [ROWS*(COLS/2)*(SYM_W+1)-1:0]   hsum_o,
   output logic [SYM_W*COLS-1:0]                vpar_o
);
   import dmc_pkg::*;

   localparam int HW   = SYM_W + 1;
   localparam int HALF = COLS / 2;
   localparam int VW   = SYM_W * COLS;

   // Integer sum of each paired symbol within a row.
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar q = 0; q < HALF; q++) begin : g_grp
         localparam int G  = grp_idx(r, q, HALF);
         localparam int SA = (r * COLS + q) * SYM_W;
         localparam int SB = (r * COLS + q + HALF) * SYM_W;
         assign hsum_o[G*HW +: HW] = HW'(data_i[SA +: SYM_W]) + HW'(data_i[SB +: SYM_W]);
      end
   end

   // Column parity across all rows.
   always_comb begin
      vpar_o = '0;
      for (int r = 0; r < ROWS; r++) begin
         vpar_o = vpar_o ^ data_i[r*VW +: VW];
      end
   end

endmodule

// File: rtl/dmc_syndrome.sv
module dmc_syndrome #(
   parameter int SYM_W = 4,
   parameter int ROWS  = 2,
   parameter int COLS  = 8
) (
   input  logic [ROWS*(COLS/2)*(SYM_W+1)-1:0] hsum_new_i,
   input  logic [ROWS*(COLS/2)*(SYM_W+1)-1:0] hsum_old_i,
   input  logic [SYM_W*COLS-1:0]              vpar_new_i,
   input  logic [SYM_W*COLS-1:0]              vpar_old_i,
   output logic [ROWS*(COLS/2)-1:0]           h_nz_o,
   output logic [SYM_W*COLS-1:0]              vsyn_o,
   output logic [COLS-1:0]                    v_nz_o
);
   localparam int HW = SYM_W + 1;
   localparam int NG = ROWS * (COLS / 2);

   // Horizontal syndrome: recomputed sum minus stored sum.
   for (genvar g = 0; g < NG; g++) begin : g_hsyn
      logic [HW-1:0] dh;
      assign dh        = hsum_new_i[g*HW +: HW] - hsum_old_i[g*HW +: HW];
      assign h_nz_o[g] = |dh;
   end

   assign vsyn_o = vpar_new_i ^ vpar_old_i;

   for (genvar p = 0; p < COLS; p++) begin : g_vcol
      assign v_nz_o[p] = |vsyn_o[p*SYM_W +: SYM_W];
   end

endmodule

// File: rtl/dmc_locfix.sv
module dmc_locfix #(
   parameter int SYM_W = 4,
   parameter int ROWS  = 2,
   parameter int COLS  = 8
) (
   input  logic [SYM_W*COLS*ROWS-1:0] data_i,
   input  logic [ROWS*(COLS/2)-1:0]   h_nz_i,
   input  logic [SYM_W*COLS-1:0]      vsyn_i,
   input  logic [COLS-1:0]            v_nz_i,
   output logic [SYM_W*COLS*ROWS-1:0] data_o,
   output logic [ROWS*COLS-1:0]       bad_o
);
   import dmc_pkg::*;

   localparam int HALF = COLS / 2;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar p = 0; p < COLS; p++) begin : g_sym
         localparam int S = r * COLS + p;
         localparam int G = grp_idx(r, p, HALF);
         // Locate: group and column both disturbed.
         assign bad_o[S] = h_nz_i[G] & v_nz_i[p];
         // Correct: invert the bits the column syndrome marks.
         assign data_o[S*SYM_W +: SYM_W] = data_i[S*SYM_W +: SYM_W]
                                         ^ (vsyn_i[p*SYM_W +: SYM_W] & {SYM_W{bad_o[S]}});
      end
   end

endmodule

// File: rtl/dmc_decoder_ert.sv
module dmc_decoder_ert #(
   parameter int SYM_W = 4,
   parameter int ROWS  = 2,
   parameter int COLS  = 8,
   localparam int HW     = SYM_W + 1,
   localparam int NG     = ROWS * (COLS / 2),
   localparam int VW     = SYM_W * COLS,
   localparam int DATA_W = VW * ROWS,
   localparam int HF_W   = NG * HW,
   localparam int CW_W   = DATA_W + HF_W + VW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_read,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CW_W-1:0]   cw_in,
   output logic [CW_W-1:0]   cw_out,
   output logic [DATA_W-1:0] rd_data,
   output logic              err_det,
   output logic              err_fix
);
   import dmc_pkg::*;

   if (COLS < 2 || (COLS % 2) != 0) begin : g_bad_cols
      $error("dmc_decoder_ert: COLS must be even and at least 2");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("dmc_decoder_ert: ROWS must be at least 2");
   end
   if (SYM_W < 1) begin : g_bad_sym
      $error("dmc_decoder_ert: SYM_W must be positive");
   end

   dmc_mode_e mode;
   assign mode = dmc_mode_e'(en_read);

   logic [DATA_W-1:0] rx_data;
   logic [HF_W-1:0]   rx_h;
   logic [VW-1:0]     rx_v;
   assign rx_data = cw_in[DATA_W-1:0];
   assign rx_h    = cw_in[DATA_W +: HF_W];
   assign rx_v    = cw_in[DATA_W+HF_W +: VW];

   // Shared generator input: write data or received data.
   logic [DATA_W-1:0] gen_in;
   logic [HF_W-1:0]   gen_h;
   logic [VW-1:0]     gen_v;
   assign gen_in = (mode == MODE_RD) ? rx_data : wr_data;

   dmc_chkgen #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_gen (
      .data_i (gen_in),
      .hsum_o (gen_h),
      .vpar_o (gen_v)
   );

   logic [NG-1:0]   h_nz;
   logic [VW-1:0]   vsyn;
   logic [COLS-1:0] v_nz;

   dmc_syndrome #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_syn (
      .hsum_new_i (gen_h),
      .hsum_old_i (rx_h),
      .vpar_new_i (gen_v),
      .vpar_old_i (rx_v),
      .h_nz_o     (h_nz),
      .vsyn_o     (vsyn),
      .v_nz_o     (v_nz)
   );

   logic [DATA_W-1:0]    fixed;
   logic [ROWS*COLS-1:0] bad;

   dmc_locfix #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_fix (
      .data_i (rx_data),
      .h_nz_i (h_nz),
      .vsyn_i (vsyn),
      .v_nz_i (v_nz),
      .data_o (fixed),
      .bad_o  (bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cw_out  <= '0;
         rd_data <= '0;
         err_det <= 1'b0;
         err_fix <= 1'b0;
      end else if (mode == MODE_RD) begin
         rd_data <= fixed;
         err_det <= (|h_nz) | (|v_nz);
         err_fix <= |bad;
      end else begin
         cw_out  <= {gen_v, gen_h, wr_data};
      end
   end

endmodule

module dmc_decoder_ert_chk #(
   parameter int DATA_W = 64,
   parameter int CW_W   = 136
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_read,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rx_data,
   input logic [CW_W-1:0]   cw_out,
   input logic [DATA_W-1:0] rd_data,
   input logic              err_det,
   input logic              err_fix
);

   a_r10_fix_needs_det: assert property (@(posedge clk) disable iff (!rst_n)
      err_fix |-> err_det);

   a_r2_write_data: assert property (@(posedge clk) disable iff (!rst_n)
      !en_read |=> (cw_out[DATA_W-1:0] == $past(wr_data)));

   a_r3_write_keeps_read: assert property (@(posedge clk) disable iff (!rst_n)
      !en_read |=> ($stable(rd_data) && $stable(err_det) && $stable(err_fix)));

   a_r4_read_keeps_cw: assert property (@(posedge clk) disable iff (!rst_n)
      en_read |=> $stable(cw_out));

   a_r5_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
      en_read |=> (err_det || (rd_data == $past(rx_data))));

endmodule

bind dmc_decoder_ert dmc_decoder_ert_chk #(.DATA_W(DATA_W), .CW_W(CW_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_read (en_read),
   .wr_data (wr_data),
   .rx_data (cw_in[DATA_W-1:0]),
   .cw_out  (cw_out),
   .rd_data (rd_data),
   .err_det (err_det),
   .err_fix (err_fix)
);

// File: tb/dmc_decoder_ert_tb.sv
module dmc_decoder_ert_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en_read = 1'b0;
   logic [63:0]  wr_data = '0;
   logic [135:0] cw_in = '0;
   logic [135:0] cw_out;
   logic [63:0]  rd_data;
   logic         err_det;
   logic         err_fix;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [63:0] last_rd = '0;
   logic        last_det = 1'b0;
   logic        last_fix = 1'b0;

   always #10 clk = ~clk;

   dmc_decoder_ert u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_read (en_read),
      .wr_data (wr_data),
      .cw_in   (cw_in),
      .cw_out  (cw_out),
      .rd_data (rd_data),
      .err_det (err_det),
      .err_fix (err_fix)
   );

   function automatic logic [3:0] sym(input logic [63:0] d, input int r, input int p);
      return d[32*r + 4*p +: 4];
   endfunction

   function automatic logic [135:0] encode(input logic [63:0] d);
      logic [39:0] h;
      logic [31:0] v;
      for (int g = 0; g < 8; g++) begin
         h[5*g +: 5] = {1'b0, sym(d, g/4, g%4)} + {1'b0, sym(d, g/4, g%4 + 4)};
      end
      for (int j = 0; j < 32; j++) v[j] = d[j] ^ d[j+32];
      return {v, h, d};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [135:0] act, input logic [135:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [63:0] d);
      logic [135:0] exp;
      exp = encode(d);
      en_read = 1'b0;
      wr_data = d;
      @(posedge clk); #1;
      check(cw_out == exp, "R2", "cw_out", cw_out, exp);
      check({rd_data, err_det, err_fix} == {last_rd, last_det, last_fix}, "R3",
            "read outputs", {rd_data, err_det, err_fix}, {last_rd, last_det, last_fix});
   endtask

   task automatic do_read(input logic [135:0] cw, input logic [63:0] exp_d,
                          input logic exp_det, input logic exp_fix, input string req);
      logic [135:0] prev_cw;
      prev_cw = cw_out;
      en_read = 1'b1;
      cw_in = cw;
      @(posedge clk); #1;
      check({rd_data, err_det, err_fix} == {exp_d, exp_det, exp_fix}, req,
            "rd_data,det,fix", {rd_data, err_det, err_fix}, {exp_d, exp_det, exp_fix});
      check(cw_out == prev_cw, "R4", "cw_out held", cw_out, prev_cw);
      last_rd = rd_data;
      last_det = err_det;
      last_fix = err_fix;
   endtask

   function automatic logic [63:0] sym_mask(input int r, input int p, input logic [3:0] m);
      logic [63:0] x;
      x = '0;
      x[32*r + 4*p +: 4] = m;
      return x;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic [63:0] e;
      logic [135:0] cw;
      void'($urandom(32'h5EED_1234));

      repeat (3) @(posedge clk);
      #1;
      check({cw_out, rd_data, err_det, err_fix} == '0, "R1", "reset state",
            {cw_out, rd_data, err_det, err_fix}, '0);
      rst_n = 1'b1;

      // Directed corners.
      do_write(64'h0);
      do_write(64'hFFFF_FFFF_FFFF_FFFF);
      do_read(encode(64'hFFFF_FFFF_FFFF_FFFF), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, "R5");
      d = 64'h0123_4567_89AB_CDEF;
      do_write(d);
      do_read(encode(d) ^ {72'h0, sym_mask(1, 7, 4'hF)}, d, 1'b1, 1'b1, "R6");
      do_read(encode(d) ^ {72'h0, sym_mask(0, 0, 4'h1)}, d, 1'b1, 1'b1, "R6");
      do_read(encode(d) ^ {72'h0, sym_mask(0, 1, 4'hA) | sym_mask(0, 6, 4'h5)},
              d, 1'b1, 1'b1, "R7");
      do_read(encode(d) ^ {32'h0, 40'h1, 64'h0}, d, 1'b1, 1'b0, "R8");
      do_read(encode(d) ^ {32'h8000_0000, 104'h0}, d, 1'b1, 1'b0, "R9");

      // Random traffic.
      for (int i = 0; i < 40; i++) begin
         d = {$urandom, $urandom};
         if (i % 4 == 0) do_write(d);
         do_read(encode(d), d, 1'b0, 1'b0, "R5");
      end
      for (int i = 0; i < 60; i++) begin
         logic [3:0] m;
         d = {$urandom, $urandom};
         m = 4'($urandom_range(1, 15));
         e = sym_mask(int'($urandom_range(0, 1)), int'($urandom_range(0, 7)), m);
         do_read(encode(d) ^ {72'h0, e}, d, 1'b1, 1'b1, "R6");
      end
      for (int i = 0; i < 30; i++) begin
         int r, p1, p2;
         d = {$urandom, $urandom};
         r = int'($urandom_range(0, 1));
         p1 = int'($urandom_range(0, 7));
         p2 = int'($urandom_range(0, 7));
         while ((p1 % 4) == (p2 % 4)) p2 = int'($urandom_range(0, 7));
         e = sym_mask(r, p1, 4'($urandom_range(1, 15)))
           | sym_mask(r, p2, 4'($urandom_range(1, 15)));
         do_read(encode(d) ^ {72'h0, e}, d, 1'b1, 1'b1, "R7");
      end
      for (int i = 0; i < 20; i++) begin
         logic [39:0] hm;
         d = {$urandom, $urandom};
         hm = {8'($urandom), $urandom};
         if (hm == '0) hm = 40'h10;
         cw = encode(d) ^ {32'h0, hm, 64'h0};
         do_read(cw, d, 1'b1, 1'b0, "R8");
      end
      for (int i = 0; i < 20; i++) begin
         logic [31:0] vm;
         d = {$urandom, $urandom};
         vm = $urandom;
         if (vm == '0) vm = 32'h1;
         do_read(encode(d) ^ {vm, 104'h0}, d, 1'b1, 1'b0, "R9");
      end
      do_write({$urandom, $urandom});
      // R10: flag consistency at the ports after a fixed and an unfixed read.
      check(!(err_fix && !err_det), "R10", "fix without det", {err_det, err_fix}, {1'b1, 1'b0});

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule